// File: doc/BRIEF.md
# FIFO Status Flag Front End

This block sits beside the transmit and receive FIFOs of a serial controller and turns FIFO activity into status, interrupt and request signals. Each FIFO is reached from two sides: the peripheral engine (the receiver pushes into the receive FIFO and the transmitter pops from the transmit FIFO) and the CPU bus (it pops from the receive FIFO and pushes into the transmit FIFO). The FIFO storage reports its fill level for the receive side and its free space for the transmit side. The block keeps two views of the flags. The first is a main status word that also feeds the interrupt status. The second is a pair of small per-FIFO error words.

The side that made an access decides where an error lands. A peripheral-side overrun or underrun goes into the main status word, into the interrupt status and into the per-FIFO word. A CPU-side misuse is recorded only in the per-FIFO word, so it can never raise an interrupt. The ready and full flags in the main status word are also sampled only on peripheral accesses. A summary error bit combines every error source. In framed modes, an end-of-frame marker can force the receive request below the threshold.

Top module: `fifo_flag_front`

## Requirements
- R1: On a cycle with `per_rx_push_i` high, sr_o[0] (receive ready) takes `rx_level_i >= rx_thr_i` and sr_o[1] (receive full) takes `rx_level_i == DEPTH`. On any other cycle both bits keep their value.
- R2: On a cycle with `per_tx_pop_i` high, sr_o[2] (transmit ready) takes `tx_free_i >= tx_thr_i`. On any other cycle it keeps its value.
- R3: A peripheral push while `rx_level_i == DEPTH` sets sr_o[3] (overrun), isr_o[2] and rx_fst_o[0]. A peripheral pop while `tx_free_i == DEPTH` (transmit FIFO empty) sets sr_o[4] (underrun), isr_o[3] and tx_fst_o[1].
- R4: A CPU read while `rx_level_i == 0` sets only rx_fst_o[1]. A CPU write while `tx_free_i == 0` sets only tx_fst_o[0]. Neither changes sr_o bits 0 to 8, isr_o or irq_o.
- R5: Pulses on `pe_i`, `fe_i` and `brk_i` set sticky bits sr_o[5], sr_o[6] and sr_o[7]. isr_o[4] is the OR of those three bits.
- R6: `rst_err_i` clears sr_o bits 3 to 7. A set of a bit in the same cycle wins over the clear.
- R7: Per-FIFO bits are sticky. Writing 1 through `rx_fst_w1c_i` or `tx_fst_w1c_i` clears the matching bit ([0] overflow, [1] underflow). A set in the same cycle wins.
- R8: sr_o[9] and `err_o` equal the OR of sr_o bits 3 to 7 and all four per-FIFO bits.
- R9: sr_o[8] (end of frame) is set by `eof_i` while `framed_i` is high. It is cleared by `sr_rd_i`, and a set in the same cycle wins over the clear.
- R10: isr_o[0] and `rx_req_o` equal receive ready OR (end of frame AND `thr_mode_i`). isr_o[1] and `tx_req_o` equal transmit ready.
- R11: `irq_o` is the OR of `isr_o & imask_i`.
- R12: After reset, all status, interrupt, request and error outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| tx_free_i | input | LVL_W | Transmit FIFO free space |
| rx_thr_i | input | LVL_W | Receive ready threshold |
| tx_thr_i | input | LVL_W | Transmit ready threshold |
| thr_mode_i | input | 1 | Threshold mode enable (allows the end-of-frame override) |
| framed_i | input | 1 | Framed mode active |
| per_rx_push_i | input | 1 | Receiver pushes into the receive FIFO |
| per_tx_pop_i | input | 1 | Transmitter pops from the transmit FIFO |
| cpu_rx_rd_i | input | 1 | CPU read strobe on the receive FIFO |
| cpu_tx_wr_i | input | 1 | CPU write strobe on the transmit FIFO |
| brk_i | input | 1 | Break detected pulse |
| fe_i | input | 1 | Framing error pulse |
| pe_i | input | 1 | Parity error pulse |
| eof_i | input | 1 | End of frame received pulse |
| sr_rd_i | input | 1 | Status read command strobe |
| rst_err_i | input | 1 | Reset-error command strobe |
| rx_fst_w1c_i | input | 2 | Write-1-to-clear for the receive FIFO error word |
| tx_fst_w1c_i | input | 2 | Write-1-to-clear for the transmit FIFO error word |
| imask_i | input | 5 | Interrupt mask, one bit per isr_o bit |
| sr_o | output | 10 | Main status word |
| isr_o | output | 5 | Interrupt status |
| rx_fst_o | output | 2 | Receive FIFO error word |
| tx_fst_o | output | 2 | Transmit FIFO error word |
| irq_o | output | 1 | Interrupt request |
| rx_req_o | output | 1 | Receive service request |
| tx_req_o | output | 1 | Transmit service request |
| err_o | output | 1 | Summary error |

## Verification
The bench targets CPU misuse at the FIFO limits. A design that routed such misuse into the main word would set overrun or underrun there, or raise `irq_o`, with no peripheral access at all. A second target is a set and a clear in the same cycle for the sticky bits, the per-FIFO bits and the end-of-frame flag. Getting the priority backwards loses an error event that arrived during a software clear. A third target is the ready flags while the CPU drains or fills the FIFO with no peripheral access. A design that tracked the level continuously would drop or raise them on those cycles. The last target is the end-of-frame override with the threshold mode toggled. A wrong gate would raise `rx_req_o` while receive ready is low and threshold mode is off.

// File: rtl/ffl_pkg.sv
package ffl_pkg;
  localparam int SR_W     = 10;
  localparam int SR_RXRDY = 0;
  localparam int SR_RXFUL = 1;
  localparam int SR_TXRDY = 2;
  localparam int SR_OVER  = 3;
  localparam int SR_UNDER = 4;
  localparam int SR_PE    = 5;
  localparam int SR_FE    = 6;
  localparam int SR_BRK   = 7;
  localparam int SR_EOF   = 8;
  localparam int SR_ERR   = 9;

  localparam int ISR_W     = 5;
  localparam int ISR_RX    = 0;
  localparam int ISR_TX    = 1;
  localparam int ISR_OVER  = 2;
  localparam int ISR_UNDER = 3;
  localparam int ISR_LINE  = 4;

  localparam int FST_W   = 2;
  localparam int FST_OVF = 0;
  localparam int FST_UNF = 1;

  typedef logic [FST_W-1:0] fst_t;
endpackage

// File: rtl/ffl_line_flags.sv
module ffl_line_flags #(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_push_i,
  input  logic             tx_pop_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] tx_free_i,
  input  logic [LVL_W-1:0] rx_thr_i,
  input  logic [LVL_W-1:0] tx_thr_i,
  input  logic             brk_i,
  input  logic             fe_i,
  input  logic             pe_i,
  input  logic             eof_i,
  input  logic             framed_i,
  input  logic             sr_rd_i,
  input  logic             rst_err_i,
  output logic             rx_rdy_o,
  output logic             rx_full_o,
  output logic             tx_rdy_o,
  output logic             over_o,
  output logic             under_o,
  output logic             pe_o,
  output logic             fe_o,
  output logic             brk_o,
  output logic             eof_o
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam int NSTK = 5;

  logic rx_rdy_q, rx_full_q, tx_rdy_q, eof_q;
  logic [NSTK-1:0] stk_set, stk_q;

  // sampled only when the peripheral side touches the FIFO
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_rdy_q  <= 1'b0;
      rx_full_q <= 1'b0;
    end else if (rx_push_i) begin
      rx_rdy_q  <= rx_level_i >= rx_thr_i;
      rx_full_q <= rx_level_i == FULL_LVL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tx_rdy_q <= 1'b0;
    else if (tx_pop_i) tx_rdy_q <= tx_free_i >= tx_thr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  eof_q <= 1'b0;
    else if (eof_i && framed_i)   eof_q <= 1'b1;
    else if (sr_rd_i)             eof_q <= 1'b0;
  end

  assign stk_set = {brk_i, fe_i, pe_i,
                    tx_pop_i && (tx_free_i == FULL_LVL),
                    rx_push_i && (rx_level_i == FULL_LVL)};

  for (genvar i = 0; i < NSTK; i++) begin : g_stk
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         q <= 1'b0;
      else if (stk_set[i]) q <= 1'b1;
      else if (rst_err_i)  q <= 1'b0;
    end
    assign stk_q[i] = q;
  end

  assign rx_rdy_o  = rx_rdy_q;
  assign rx_full_o = rx_full_q;
  assign tx_rdy_o  = tx_rdy_q;
  assign eof_o     = eof_q;
  assign over_o    = stk_q[0];
  assign under_o   = stk_q[1];
  assign pe_o      = stk_q[2];
  assign fe_o      = stk_q[3];
  assign brk_o     = stk_q[4];

  a_r1_rx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_push_i |=> $stable(rx_rdy_o) && $stable(rx_full_o));
  a_r2_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_pop_i |=> $stable(tx_rdy_o));
  a_r9_eof_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_rd_i && !(eof_i && framed_i) |=> !eof_o);
  a_r6_err_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_err_i && (stk_set == '0) |=> !over_o && !under_o && !pe_o && !fe_o && !brk_o);
  a_r3_over_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_i && (rx_level_i == FULL_LVL) |=> over_o);
endmodule

// File: rtl/ffl_err_reg.sv
module ffl_err_reg
  import ffl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  fst_t set_i,
  input  fst_t w1c_i,
  output fst_t st_o
);
  for (genvar i = 0; i < FST_W; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;
      else if (w1c_i[i]) q <= 1'b0;
    end
    assign st_o[i] = q;

    a_r7_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
      w1c_i[i] && !set_i[i] |=> !st_o[i]);
    a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st_o[i] && !w1c_i[i] |=> st_o[i]);
  end
endmodule

// File: rtl/ffl_irq_gen.sv
module ffl_irq_gen
  import ffl_pkg::*;
(
  input  logic             rx_rdy_i,
  input  logic             tx_rdy_i,
  input  logic             over_i,
  input  logic             under_i,
  input  logic             pe_i,
  input  logic             fe_i,
  input  logic             brk_i,
  input  logic             eof_i,
  input  logic             thr_mode_i,
  input  fst_t             rx_fst_i,
  input  fst_t             tx_fst_i,
  input  logic [ISR_W-1:0] imask_i,
  output logic [ISR_W-1:0] isr_o,
  output logic             irq_o,
  output logic             rx_req_o,
  output logic             tx_req_o,
  output logic             err_o
);
  logic rx_svc, line_err;

  // end of frame forces the receive request below threshold
  assign rx_svc   = rx_rdy_i | (eof_i & thr_mode_i);
  assign line_err = pe_i | fe_i | brk_i;

  always_comb begin
    isr_o            = '0;
    isr_o[ISR_RX]    = rx_svc;
    isr_o[ISR_TX]    = tx_rdy_i;
    isr_o[ISR_OVER]  = over_i;
    isr_o[ISR_UNDER] = under_i;
    isr_o[ISR_LINE]  = line_err;
  end

  assign irq_o    = |(isr_o & imask_i);
  assign rx_req_o = rx_svc;
  assign tx_req_o = tx_rdy_i;
  assign err_o    = over_i | under_i | line_err | (|rx_fst_i) | (|tx_fst_i);
endmodule

// File: rtl/fifo_flag_front.sv
module fifo_flag_front
  import ffl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] tx_free_i,
  input  logic [LVL_W-1:0] rx_thr_i,
  input  logic [LVL_W-1:0] tx_thr_i,
  input  logic             thr_mode_i,
  input  logic             framed_i,
  input  logic             per_rx_push_i,
  input  logic             per_tx_pop_i,
  input  logic             cpu_rx_rd_i,
  input  logic             cpu_tx_wr_i,
  input  logic             brk_i,
  input  logic             fe_i,
  input  logic             pe_i,
  input  logic             eof_i,
  input  logic             sr_rd_i,
  input  logic             rst_err_i,
  input  logic [1:0]       rx_fst_w1c_i,
  input  logic [1:0]       tx_fst_w1c_i,
  input  logic [4:0]       imask_i,
  output logic [9:0]       sr_o,
  output logic [4:0]       isr_o,
  output logic [1:0]       rx_fst_o,
  output logic [1:0]       tx_fst_o,
  output logic             irq_o,
  output logic             rx_req_o,
  output logic             tx_req_o,
  output logic             err_o
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic rx_rdy, rx_full, tx_rdy, over, under, pe, fe, brk, eof;
  fst_t rx_set, tx_set, rx_fst, tx_fst;

  ffl_line_flags #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_line (
    .clk_i, .rst_ni,
    .rx_push_i (per_rx_push_i),
    .tx_pop_i  (per_tx_pop_i),
    .rx_level_i, .tx_free_i, .rx_thr_i, .tx_thr_i,
    .brk_i, .fe_i, .pe_i, .eof_i, .framed_i, .sr_rd_i, .rst_err_i,
    .rx_rdy_o (rx_rdy), .rx_full_o (rx_full), .tx_rdy_o (tx_rdy),
    .over_o (over), .under_o (under), .pe_o (pe), .fe_o (fe),
    .brk_o (brk), .eof_o (eof)
  );

  // receive FIFO: peripheral overflow, CPU underflow; transmit FIFO mirrored
  always_comb begin
    rx_set          = '0;
    rx_set[FST_OVF] = per_rx_push_i && (rx_level_i == FULL_LVL);
    rx_set[FST_UNF] = cpu_rx_rd_i   && (rx_level_i == '0);
    tx_set          = '0;
    tx_set[FST_OVF] = cpu_tx_wr_i   && (tx_free_i == '0);
    tx_set[FST_UNF] = per_tx_pop_i  && (tx_free_i == FULL_LVL);
  end

  ffl_err_reg u_rx_err (.clk_i, .rst_ni, .set_i (rx_set), .w1c_i (rx_fst_w1c_i), .st_o (rx_fst));
  ffl_err_reg u_tx_err (.clk_i, .rst_ni, .set_i (tx_set), .w1c_i (tx_fst_w1c_i), .st_o (tx_fst));

  ffl_irq_gen u_irq (
    .rx_rdy_i (rx_rdy), .tx_rdy_i (tx_rdy), .over_i (over), .under_i (under),
    .pe_i (pe), .fe_i (fe), .brk_i (brk), .eof_i (eof), .thr_mode_i,
    .rx_fst_i (rx_fst), .tx_fst_i (tx_fst), .imask_i,
    .isr_o, .irq_o, .rx_req_o, .tx_req_o, .err_o
  );

  always_comb begin
    sr_o           = '0;
    sr_o[SR_RXRDY] = rx_rdy;
    sr_o[SR_RXFUL] = rx_full;
    sr_o[SR_TXRDY] = tx_rdy;
    sr_o[SR_OVER]  = over;
    sr_o[SR_UNDER] = under;
    sr_o[SR_PE]    = pe;
    sr_o[SR_FE]    = fe;
    sr_o[SR_BRK]   = brk;
    sr_o[SR_EOF]   = eof;
    sr_o[SR_ERR]   = err_o;
  end

  assign rx_fst_o = rx_fst;
  assign tx_fst_o = tx_fst;

  a_r4_no_cpu_over: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !per_rx_push_i |=> !$rose(sr_o[SR_OVER]));
  a_r4_no_cpu_under: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !per_tx_pop_i |=> !$rose(sr_o[SR_UNDER]));
  a_r10_eof_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_o[SR_EOF] && thr_mode_i |-> rx_req_o);
  a_r11_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imask_i == '0) |-> !irq_o);
  a_r8_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_fst_o != '0) |-> err_o);
endmodule

// File: tb/test_fifo_flag_front.sv
module test_fifo_flag_front;
  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [LVL_W-1:0] rx_level_i, tx_free_i, rx_thr_i, tx_thr_i;
  logic thr_mode_i, framed_i, per_rx_push_i, per_tx_pop_i, cpu_rx_rd_i, cpu_tx_wr_i;
  logic brk_i, fe_i, pe_i, eof_i, sr_rd_i, rst_err_i;
  logic [1:0] rx_fst_w1c_i, tx_fst_w1c_i;
  logic [4:0] imask_i;
  logic [9:0] sr_o;
  logic [4:0] isr_o;
  logic [1:0] rx_fst_o, tx_fst_o;
  logic irq_o, rx_req_o, tx_req_o, err_o;

  int checks = 0, errors = 0;

  always #10 clk_i = ~clk_i;

  fifo_flag_front #(.DEPTH(DEPTH)) i_fifo_flag_front (.*);

  // reference model state
  bit m_rxr, m_rxf, m_txr, m_ov, m_un, m_pe, m_fe, m_bk, m_eof;
  bit [1:0] m_rfs, m_tfs;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {m_rxr, m_rxf, m_txr, m_ov, m_un, m_pe, m_fe, m_bk, m_eof} <= '0;
      m_rfs <= '0; m_tfs <= '0;
    end else begin
      bit rfull, rempty, tfull, tempty;
      rfull  = int'(rx_level_i) == DEPTH;
      rempty = rx_level_i == 0;
      tempty = int'(tx_free_i) == DEPTH;
      tfull  = tx_free_i == 0;
      if (per_rx_push_i) begin
        m_rxr <= rx_level_i >= rx_thr_i;
        m_rxf <= rfull;
      end
      if (per_tx_pop_i) m_txr <= tx_free_i >= tx_thr_i;
      m_ov <= (per_rx_push_i && rfull) ? 1'b1 : (rst_err_i ? 1'b0 : m_ov);
      m_un <= (per_tx_pop_i && tempty) ? 1'b1 : (rst_err_i ? 1'b0 : m_un);
      m_pe <= pe_i  ? 1'b1 : (rst_err_i ? 1'b0 : m_pe);
      m_fe <= fe_i  ? 1'b1 : (rst_err_i ? 1'b0 : m_fe);
      m_bk <= brk_i ? 1'b1 : (rst_err_i ? 1'b0 : m_bk);
      m_eof <= (eof_i && framed_i) ? 1'b1 : (sr_rd_i ? 1'b0 : m_eof);
      m_rfs[0] <= (per_rx_push_i && rfull)  ? 1'b1 : (rx_fst_w1c_i[0] ? 1'b0 : m_rfs[0]);
      m_rfs[1] <= (cpu_rx_rd_i && rempty)   ? 1'b1 : (rx_fst_w1c_i[1] ? 1'b0 : m_rfs[1]);
      m_tfs[0] <= (cpu_tx_wr_i && tfull)    ? 1'b1 : (tx_fst_w1c_i[0] ? 1'b0 : m_tfs[0]);
      m_tfs[1] <= (per_tx_pop_i && tempty)  ? 1'b1 : (tx_fst_w1c_i[1] ? 1'b0 : m_tfs[1]);
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit err, rxs, line;
    bit [4:0] isr;
    err  = m_ov | m_un | m_pe | m_fe | m_bk | (|m_rfs) | (|m_tfs);
    rxs  = m_rxr | (m_eof & thr_mode_i);
    line = m_pe | m_fe | m_bk;
    isr  = {line, m_un, m_ov, m_txr, rxs};
    chk("R1", "sr rx ready/full", int'(sr_o[1:0]), int'({m_rxf, m_rxr}));
    chk("R2", "sr tx ready", int'(sr_o[2]), int'(m_txr));
    chk("R3", "sr over/under", int'(sr_o[4:3]), int'({m_un, m_ov}));
    chk("R5", "sr line errors", int'(sr_o[7:5]), int'({m_bk, m_fe, m_pe}));
    chk("R9", "sr eof", int'(sr_o[8]), int'(m_eof));
    chk("R8", "summary error", int'({sr_o[9], err_o}), int'({err, err}));
    chk("R10", "isr", int'(isr_o), int'(isr));
    chk("R10", "requests", int'({rx_req_o, tx_req_o}), int'({rxs, m_txr}));
    chk("R7", "rx fifo word", int'(rx_fst_o), int'(m_rfs));
    chk("R7", "tx fifo word", int'(tx_fst_o), int'(m_tfs));
    chk("R11", "irq", int'(irq_o), int'(|(isr & imask_i)));
  endtask

  task automatic idle_pulses();
    {per_rx_push_i, per_tx_pop_i, cpu_rx_rd_i, cpu_tx_wr_i} = '0;
    {brk_i, fe_i, pe_i, eof_i, sr_rd_i, rst_err_i} = '0;
    rx_fst_w1c_i = '0; tx_fst_w1c_i = '0;
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
    compare_all();
    idle_pulses();
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_pulses();
    rx_level_i = '0; tx_free_i = LVL_W'(DEPTH);
    rx_thr_i = 5'd4; tx_thr_i = 5'd4;
    thr_mode_i = 1'b0; framed_i = 1'b0; imask_i = '1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R12 reset state
    chk("R12", "reset sr", int'(sr_o), 0);
    chk("R12", "reset isr/irq/req/err", int'({isr_o, irq_o, rx_req_o, tx_req_o, err_o}), 0);
    chk("R12", "reset fifo words", int'({rx_fst_o, tx_fst_o}), 0);

    // R4 CPU misuse: read empty rx, write full tx
    rx_level_i = '0; cpu_rx_rd_i = 1'b1;
    tx_free_i = '0;  cpu_tx_wr_i = 1'b1;
    tick();
    chk("R4", "cpu misuse fifo words", int'({rx_fst_o, tx_fst_o}), 4'b1001);
    chk("R4", "cpu misuse sr/isr/irq", int'({sr_o[8:0], isr_o, irq_o}), 0);

    // R1 CPU drain without peripheral access keeps ready
    rx_level_i = 5'd6; per_rx_push_i = 1'b1; tick();
    rx_level_i = 5'd0; cpu_rx_rd_i = 1'b0; tick();
    chk("R1", "rx ready held without push", int'(sr_o[0]), 1);

    // R3 peripheral overrun and underrun
    rx_level_i = LVL_W'(DEPTH); per_rx_push_i = 1'b1;
    tx_free_i = LVL_W'(DEPTH); per_tx_pop_i = 1'b1;
    tick();
    chk("R3", "over/under in sr,isr,words",
        int'({sr_o[4:3], isr_o[3:2], rx_fst_o[0], tx_fst_o[1]}), 6'b111111);

    // R6 clear coincident with new overrun: set wins, under cleared
    per_rx_push_i = 1'b1; rst_err_i = 1'b1; tick();
    chk("R6", "set wins over reset-error", int'(sr_o[4:3]), 2'b01);

    // R7 w1c coincident with set
    rx_level_i = 5'd0; cpu_rx_rd_i = 1'b1; rx_fst_w1c_i = 2'b11; tick();
    chk("R7", "w1c with coincident set", int'(rx_fst_o), 2'b10);

    // R9/R10 eof override
    framed_i = 1'b1; thr_mode_i = 1'b0;
    rx_level_i = 5'd1; per_rx_push_i = 1'b1; tick();
    eof_i = 1'b1; tick();
    chk("R10", "no override with threshold mode off", int'(rx_req_o), 0);
    thr_mode_i = 1'b1; @(negedge clk_i); compare_all();
    chk("R10", "override raises rx request", int'({rx_req_o, isr_o[0]}), 2'b11);
    eof_i = 1'b1; sr_rd_i = 1'b1; tick();
    chk("R9", "eof set wins over read", int'(sr_o[8]), 1);
    sr_rd_i = 1'b1; tick();
    chk("R9", "eof cleared by read", int'(sr_o[8]), 0);
    framed_i = 1'b0; eof_i = 1'b1; tick();
    chk("R9", "eof ignored outside framed mode", int'(sr_o[8]), 0);

    // R5/R11 line errors with masks
    imask_i = 5'b10000; pe_i = 1'b1; tick();
    chk("R5", "parity sets line bit", int'({sr_o[5], isr_o[4]}), 2'b11);
    chk("R11", "masked line irq", int'(irq_o), 1);
    imask_i = '0; tick();
    chk("R11", "all masked", int'(irq_o), 0);

    // random phase, model compared every cycle
    for (int n = 0; n < 4000; n++) begin
      rx_level_i    = LVL_W'($urandom_range(DEPTH, 0));
      tx_free_i     = LVL_W'($urandom_range(DEPTH, 0));
      if ($urandom_range(15, 0) == 0) begin
        rx_thr_i = LVL_W'($urandom_range(DEPTH, 0));
        tx_thr_i = LVL_W'($urandom_range(DEPTH, 0));
      end
      thr_mode_i    = $urandom_range(3, 0) != 0;
      framed_i      = $urandom_range(1, 0) != 0;
      imask_i       = 5'($urandom_range(31, 0));
      per_rx_push_i = $urandom_range(3, 0) == 0;
      per_tx_pop_i  = $urandom_range(3, 0) == 0;
      cpu_rx_rd_i   = $urandom_range(3, 0) == 0;
      cpu_tx_wr_i   = $urandom_range(3, 0) == 0;
      brk_i         = $urandom_range(31, 0) == 0;
      fe_i          = $urandom_range(31, 0) == 0;
      pe_i          = $urandom_range(31, 0) == 0;
      eof_i         = $urandom_range(7, 0) == 0;
      sr_rd_i       = $urandom_range(7, 0) == 0;
      rst_err_i     = $urandom_range(15, 0) == 0;
      rx_fst_w1c_i  = ($urandom_range(7, 0) == 0) ? 2'($urandom_range(3, 0)) : 2'b00;
      tx_fst_w1c_i  = ($urandom_range(7, 0) == 0) ? 2'($urandom_range(3, 0)) : 2'b00;
      tick();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule